// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the byte-wide register face of an asynchronous serial port. Software reaches it through a single-cycle read/write strobe pair on a small address space. It holds one status register and two control registers. It also holds a 12-bit baud divisor, split over a low and a high byte, and a one-byte receive holding register. Received bytes arrive on a valid/ready byte stream. Bytes that software writes to the data address leave on a transmit byte stream. Serial bit timing and framing live elsewhere and consume the divisor output.

Three level interrupt lines report receive done, transmit done and data register empty. A power-down input holds the whole block in its reset state for as long as it is high. While it is high, the block answers every read with zero and drops every write.

Top module: `serial_csr`

## Requirements
- R1: After reset the registers read: status 0x20, control 0x00, format 0x06, baud low 0x00 and baud high 0x00. The receive-ready output and all three interrupt outputs are low. The address map is status=0, control=1, format=2, baud low=4, baud high=5, data=6.
- R2: A status write stores only bits 6, 1 and 0 (mask 0x43); the other bits keep their value. Bit 6 (transmit done) always reads 0 after the write. Writing 1 to bit 6 also drops the transmit-done interrupt.
- R3: A control write stores every bit except bit 1, which keeps its value (mask 0xFD). A format write stores the whole byte. A baud high write keeps only its low 4 bits. The divisor output is {baud high[3:0], baud low}.
- R4: The character size code is {control bit 2, format bit 2, format bit 1}. Codes 0, 1, 2 and 3 select a mask of 5, 6, 7 and 8 low bits. Code 7 selects 8 bits. Codes 4 to 6 keep the previous mask. The mask is re-evaluated on every control or format write.
- R5: The receive stream is accepted (ready high) only when control bit 4 (receiver enable) is set and no byte is held. On acceptance the byte is held and status bit 7 (receive done) is set. The receive interrupt is raised if control bit 7 was set.
- R6: Reading data while the receiver is disabled returns 0 and changes nothing. Otherwise the read returns the held byte ANDed with the mask, or 0 if no byte is held. The read then empties the holder, clears status bit 7 and drops the receive interrupt.
- R7: A data write is ignored while control bit 3 (transmitter enable) is clear. Otherwise it sets status bits 6 and 5. With control bit 6 set, it raises the transmit interrupt and clears bit 6 at once. With control bit 5 set, it raises the empty interrupt.
- R8: Every control write recomputes the interrupts: receive = bit 7 AND status bit 7, transmit = bit 6 AND status bit 6, empty = bit 5 AND status bit 5. If the write leaves bit 4 clear, the held byte is discarded while status bit 7 keeps its value.
- R9: While the power-down input is high, the block is held in its reset state. Reads return 0, writes are ignored and receive-ready is low.
- R10: Address 3 and address 7 read as 0, and writes to them change nothing.
- R11: Each accepted data write presents its byte on the transmit stream with a valid strobe for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_off_i | input | 1 | Power-down, holds reset state while high |
| addr_i | input | 3 | Register byte address |
| rd_i | input | 1 | Read strobe, side effects on the clock edge |
| wr_i | input | 1 | Write strobe, takes priority over rd_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational during a read, else 0 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_ready_o | output | 1 | Receive holder can accept a byte |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Transmit byte |
| baud_o | output | 12 | Baud divisor |
| irq_rx_o | output | 1 | Receive done interrupt |
| irq_tx_o | output | 1 | Transmit done interrupt |
| irq_empty_o | output | 1 | Data register empty interrupt |

## Verification
The bench targets the masking corners: the read-only control bit and the truncated baud high byte, and a status write whose transmit-done bit comes back zero. Mistakes here show up as stray bits on readback. It walks the size codes through a reserved code after different predecessors, so a design that decodes reserved codes to a fixed mask returns the wrong number of data bits. It exercises the transmit write with the transmit interrupt enabled, where the flag must stay clear while the line rises. It also checks that a disabled-receiver data read neither clears receive done nor the discard. Finally, it drives bytes into a full holder and while power-down is high; a design that overwrites the holder or leaks state through power-down returns the wrong byte or a non-reset register.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;
  localparam int unsigned DW = 8;
  typedef logic [DW-1:0] byte_t;

  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTLB = 3'd1;
  localparam logic [2:0] A_CTLC = 3'd2;
  localparam logic [2:0] A_BLO  = 3'd4;
  localparam logic [2:0] A_BHI  = 3'd5;
  localparam logic [2:0] A_DATA = 3'd6;

  // status bits
  localparam int unsigned ST_RXD = 7;
  localparam int unsigned ST_TXD = 6;
  localparam int unsigned ST_EMP = 5;
  // control bits
  localparam int unsigned CB_RXIE = 7;
  localparam int unsigned CB_TXIE = 6;
  localparam int unsigned CB_EIE  = 5;
  localparam int unsigned CB_RXEN = 4;
  localparam int unsigned CB_TXEN = 3;
  localparam int unsigned CB_SZ2  = 2;
  // format bits
  localparam int unsigned CC_SZ1 = 2;
  localparam int unsigned CC_SZ0 = 1;

  localparam byte_t STAT_RST   = 8'h20;
  localparam byte_t CTLC_RST   = 8'h06;
  localparam byte_t STAT_WMASK = 8'h43;
  localparam byte_t CTLB_WMASK = 8'hFD;

  localparam int unsigned MIN_CHAR = 5;

  function automatic byte_t size_mask(logic [2:0] code, byte_t prev);
    byte_t m;
    if (!code[2]) m = byte_t'((16'd1 << (16'(code) + 16'(MIN_CHAR))) - 16'd1);
    else if (code == 3'd7) m = '1;
    else m = prev;
    return m;
  endfunction
endpackage

// File: rtl/serial_csr_cfg.sv
module serial_csr_cfg
  import serial_csr_pkg::*;
#(
  parameter int unsigned BAUD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_ctlb_i,
  input  logic              wr_ctlc_i,
  input  logic              wr_blo_i,
  input  logic              wr_bhi_i,
  input  byte_t             wdata_i,
  output byte_t             ctlb_o,
  output byte_t             ctlb_nxt_o,
  output byte_t             ctlc_o,
  output logic [BAUD_W-1:0] baud_o,
  output byte_t             mask_o
);
  localparam int unsigned BHI_W = BAUD_W - DW;
  localparam byte_t MASK_RST = size_mask({1'b0, CTLC_RST[CC_SZ1], CTLC_RST[CC_SZ0]}, '1);

  byte_t ctlb_q, ctlc_q, blo_q, mask_q;
  logic [BHI_W-1:0] bhi_q;
  logic [2:0] code_nxt;

  assign ctlb_nxt_o = (wdata_i & CTLB_WMASK) | (ctlb_q & ~CTLB_WMASK);

  always_comb begin
    code_nxt[2] = wr_ctlb_i ? ctlb_nxt_o[CB_SZ2] : ctlb_q[CB_SZ2];
    code_nxt[1] = wr_ctlc_i ? wdata_i[CC_SZ1] : ctlc_q[CC_SZ1];
    code_nxt[0] = wr_ctlc_i ? wdata_i[CC_SZ0] : ctlc_q[CC_SZ0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctlb_q <= '0;
      ctlc_q <= CTLC_RST;
      blo_q  <= '0;
      bhi_q  <= '0;
      mask_q <= MASK_RST;
    end else if (clr_i) begin
      ctlb_q <= '0;
      ctlc_q <= CTLC_RST;
      blo_q  <= '0;
      bhi_q  <= '0;
      mask_q <= MASK_RST;
    end else begin
      if (wr_ctlb_i) ctlb_q <= ctlb_nxt_o;
      if (wr_ctlc_i) ctlc_q <= wdata_i;
      if (wr_blo_i)  blo_q  <= wdata_i;
      if (wr_bhi_i)  bhi_q  <= wdata_i[BHI_W-1:0];
      if (wr_ctlb_i || wr_ctlc_i) mask_q <= size_mask(code_nxt, mask_q);
    end
  end

  assign ctlb_o = ctlb_q;
  assign ctlc_o = ctlc_q;
  assign baud_o = {bhi_q, blo_q};
  assign mask_o = mask_q;

  // R4: only the four legal masks can ever be held
  p_mask_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == 8'h1F) || (mask_q == 8'h3F) || (mask_q == 8'h7F) || (mask_q == 8'hFF));

  // R4: a reserved code keeps the mask
  p_reserved_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_ctlb_i || wr_ctlc_i) && !clr_i && code_nxt[2] && (code_nxt != 3'd7))
    |=> $stable(mask_q));
endmodule

// File: rtl/serial_csr_rxbuf.sv
module serial_csr_rxbuf
  import serial_csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  clr_i,
  input  logic  rx_en_i,
  input  logic  rd_clr_i,
  input  logic  discard_i,
  input  logic  rx_valid_i,
  input  byte_t rx_data_i,
  input  byte_t mask_i,
  output logic  rx_ready_o,
  output logic  rx_accept_o,
  output byte_t rd_byte_o
);
  logic  valid_q;
  byte_t data_q;

  assign rx_ready_o  = rx_en_i & ~valid_q & ~clr_i;
  assign rx_accept_o = rx_valid_i & rx_ready_o;
  assign rd_byte_o   = valid_q ? (data_q & mask_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      if (rd_clr_i || discard_i) valid_q <= 1'b0;
      if (rx_accept_o) begin
        valid_q <= 1'b1;
        data_q  <= rx_data_i;
      end
    end
  end

  // R5: an accepted byte is held unchanged
  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_accept_o |=> (valid_q && (data_q == $past(rx_data_i))));

  // R6: a data read empties the holder
  p_read_empties_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !rx_accept_o) |=> !valid_q);
endmodule

// File: rtl/serial_csr_flags.sv
module serial_csr_flags
  import serial_csr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       wr_stat_i,
  input  byte_t      wdata_i,
  input  logic       tx_fire_i,
  input  logic       rd_clr_i,
  input  logic       rx_accept_i,
  input  logic       wr_ctlb_i,
  input  logic [2:0] ie_cur_i,   // {rx, tx, empty}
  input  logic [2:0] ie_nxt_i,
  output byte_t      stat_o,
  output logic       irq_rx_o,
  output logic       irq_tx_o,
  output logic       irq_empty_o
);
  byte_t stat_q, stat_w;
  logic  irq_rx_q, irq_tx_q, irq_emp_q;

  assign stat_w = (wdata_i & STAT_WMASK) | (stat_q & ~STAT_WMASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q    <= STAT_RST;
      irq_rx_q  <= 1'b0;
      irq_tx_q  <= 1'b0;
      irq_emp_q <= 1'b0;
    end else if (clr_i) begin
      stat_q    <= STAT_RST;
      irq_rx_q  <= 1'b0;
      irq_tx_q  <= 1'b0;
      irq_emp_q <= 1'b0;
    end else begin
      if (wr_stat_i) begin
        stat_q         <= stat_w;
        stat_q[ST_TXD] <= 1'b0;  // written 0 stores 0, written 1 clears
        if (stat_w[ST_TXD]) irq_tx_q <= 1'b0;
      end
      if (wr_ctlb_i) begin
        irq_rx_q  <= ie_nxt_i[2] & stat_q[ST_RXD];
        irq_tx_q  <= ie_nxt_i[1] & stat_q[ST_TXD];
        irq_emp_q <= ie_nxt_i[0] & stat_q[ST_EMP];
      end
      if (tx_fire_i) begin
        stat_q[ST_EMP] <= 1'b1;
        stat_q[ST_TXD] <= ~ie_cur_i[1];
        if (ie_cur_i[1]) irq_tx_q  <= 1'b1;
        if (ie_cur_i[0]) irq_emp_q <= 1'b1;
      end
      if (rd_clr_i) begin
        stat_q[ST_RXD] <= 1'b0;
        irq_rx_q       <= 1'b0;
      end
      if (rx_accept_i) begin
        stat_q[ST_RXD] <= 1'b1;
        if (ie_cur_i[2]) irq_rx_q <= 1'b1;
      end
    end
  end

  assign stat_o      = stat_q;
  assign irq_rx_o    = irq_rx_q;
  assign irq_tx_o    = irq_tx_q;
  assign irq_empty_o = irq_emp_q;

  // R2: write-one clears transmit done and its interrupt
  p_w1c_txd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat_i && wdata_i[ST_TXD] && !clr_i) |=> (!stat_q[ST_TXD] && !irq_tx_q));

  // R7: an accepted transmit write leaves the empty flag set
  p_tx_sets_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_fire_i && !clr_i) |=> stat_q[ST_EMP]);

  // R8: control write recomputes every line from enable AND flag
  p_irq_recompute_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ctlb_i && !clr_i && !rx_accept_i)
    |=> ({irq_rx_q, irq_tx_q, irq_emp_q} ==
         $past(ie_nxt_i & {stat_q[ST_RXD], stat_q[ST_TXD], stat_q[ST_EMP]})));
endmodule

// File: rtl/serial_csr.sv
module serial_csr
  import serial_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BAUD_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_off_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic [BAUD_W-1:0] baud_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o,
  output logic              irq_empty_o
);
  logic wr_en, rd_en;
  logic sel_stat, sel_ctlb, sel_ctlc, sel_blo, sel_bhi, sel_data;
  logic wr_ctlb, tx_fire, rd_clr, discard, rx_accept;
  byte_t ctlb, ctlb_nxt, ctlc, mask, stat, rd_byte;

  assign wr_en = wr_i & ~pwr_off_i;
  assign rd_en = rd_i & ~wr_i & ~pwr_off_i;

  assign sel_stat = (addr_i == ADDR_W'(A_STAT));
  assign sel_ctlb = (addr_i == ADDR_W'(A_CTLB));
  assign sel_ctlc = (addr_i == ADDR_W'(A_CTLC));
  assign sel_blo  = (addr_i == ADDR_W'(A_BLO));
  assign sel_bhi  = (addr_i == ADDR_W'(A_BHI));
  assign sel_data = (addr_i == ADDR_W'(A_DATA));

  assign wr_ctlb = wr_en & sel_ctlb;
  assign tx_fire = wr_en & sel_data & ctlb[CB_TXEN];
  assign rd_clr  = rd_en & sel_data & ctlb[CB_RXEN];
  assign discard = wr_ctlb & ~ctlb_nxt[CB_RXEN];

  serial_csr_cfg #(.BAUD_W(BAUD_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (pwr_off_i),
    .wr_ctlb_i  (wr_ctlb),
    .wr_ctlc_i  (wr_en & sel_ctlc),
    .wr_blo_i   (wr_en & sel_blo),
    .wr_bhi_i   (wr_en & sel_bhi),
    .wdata_i    (wdata_i),
    .ctlb_o     (ctlb),
    .ctlb_nxt_o (ctlb_nxt),
    .ctlc_o     (ctlc),
    .baud_o     (baud_o),
    .mask_o     (mask)
  );

  serial_csr_rxbuf u_rxbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pwr_off_i),
    .rx_en_i     (ctlb[CB_RXEN]),
    .rd_clr_i    (rd_clr),
    .discard_i   (discard),
    .rx_valid_i  (rx_valid_i),
    .rx_data_i   (rx_data_i),
    .mask_i      (mask),
    .rx_ready_o  (rx_ready_o),
    .rx_accept_o (rx_accept),
    .rd_byte_o   (rd_byte)
  );

  serial_csr_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (pwr_off_i),
    .wr_stat_i   (wr_en & sel_stat),
    .wdata_i     (wdata_i),
    .tx_fire_i   (tx_fire),
    .rd_clr_i    (rd_clr),
    .rx_accept_i (rx_accept),
    .wr_ctlb_i   (wr_ctlb),
    .ie_cur_i    ({ctlb[CB_RXIE], ctlb[CB_TXIE], ctlb[CB_EIE]}),
    .ie_nxt_i    ({ctlb_nxt[CB_RXIE], ctlb_nxt[CB_TXIE], ctlb_nxt[CB_EIE]}),
    .stat_o      (stat),
    .irq_rx_o    (irq_rx_o),
    .irq_tx_o    (irq_tx_o),
    .irq_empty_o (irq_empty_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en) begin
      unique case (1'b1)
        sel_stat: rdata_o = stat;
        sel_ctlb: rdata_o = ctlb;
        sel_ctlc: rdata_o = ctlc;
        sel_blo:  rdata_o = baud_o[DW-1:0];
        sel_bhi:  rdata_o = DW'(baud_o[BAUD_W-1:DW]);
        sel_data: rdata_o = ctlb[CB_RXEN] ? rd_byte : '0;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign tx_valid_o = tx_fire;
  assign tx_data_o  = wdata_i;

  // R9: nothing leaves the block while powered down
  p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |-> ((rdata_o == 8'h00) && !tx_valid_o && !rx_ready_o));

  // R9: power-down drops every interrupt
  p_off_irq_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_i |=> (!irq_rx_o && !irq_tx_o && !irq_empty_o));

  // R10: the hole in the map reads zero
  p_hole_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i == ADDR_W'(3))) |-> (rdata_o == 8'h00));
endmodule

// File: tb/serial_csr_tb_top.sv
module serial_csr_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic off = 1'b0;
  logic rd = 1'b0, wr = 1'b0, rxv = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wd = '0, rxd = '0;

  logic [7:0]  rdata, tx_data;
  logic [11:0] baud;
  logic rx_ready, tx_valid, irq_rx, irq_tx, irq_emp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string req = "R1";

  always #4 clk = ~clk;

  serial_csr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_off_i(off), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wd), .rdata_o(rdata),
    .rx_valid_i(rxv), .rx_data_i(rxd), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .baud_o(baud),
    .irq_rx_o(irq_rx), .irq_tx_o(irq_tx), .irq_empty_o(irq_emp)
  );

  // reference model state
  logic [7:0] m_stat, m_cb, m_cc, m_blo, m_bhi, m_dat, m_mask;
  bit m_val, m_irx, m_itx, m_iem;

  task automatic m_reset();
    m_stat = 8'h20; m_cb = 8'h00; m_cc = 8'h06; m_blo = 8'h00; m_bhi = 8'h00;
    m_dat = 8'h00; m_mask = 8'hFF; m_val = 0; m_irx = 0; m_itx = 0; m_iem = 0;
  endtask

  function automatic logic [7:0] m_newmask(logic [2:0] c, logic [7:0] prev);
    case (c)
      3'd0: return 8'h1F;
      3'd1: return 8'h3F;
      3'd2: return 8'h7F;
      3'd3: return 8'hFF;
      3'd7: return 8'hFF;
      default: return prev;
    endcase
  endfunction

  task automatic m_tick();
    logic [7:0] cb_old;
    bit acc;
    if (!rst_n || off) begin m_reset(); return; end
    cb_old = m_cb;
    acc = rxv && cb_old[4] && !m_val;
    if (wr) begin
      case (addr)
        3'd0: begin
          m_stat = (wd & 8'h43) | (m_stat & 8'hBC);
          if (m_stat[6]) begin m_stat[6] = 1'b0; m_itx = 0; end
        end
        3'd1: begin
          m_cb = (wd & 8'hFD) | (m_cb & 8'h02);
          if (!m_cb[4]) m_val = 0;
          m_irx = m_cb[7] & m_stat[7];
          m_itx = m_cb[6] & m_stat[6];
          m_iem = m_cb[5] & m_stat[5];
          m_mask = m_newmask({m_cb[2], m_cc[2], m_cc[1]}, m_mask);
        end
        3'd2: begin
          m_cc = wd;
          m_mask = m_newmask({m_cb[2], m_cc[2], m_cc[1]}, m_mask);
        end
        3'd4: m_blo = wd;
        3'd5: m_bhi = wd & 8'h0F;
        3'd6: if (m_cb[3]) begin
          m_stat[6] = 1'b1; m_stat[5] = 1'b1;
          if (m_cb[6]) begin m_itx = 1; m_stat[6] = 1'b0; end
          if (m_cb[5]) m_iem = 1;
        end
        default: ;
      endcase
    end else if (rd && addr == 3'd6 && m_cb[4]) begin
      m_val = 0; m_stat[7] = 1'b0; m_irx = 0;
    end
    if (acc) begin
      m_dat = rxd; m_val = 1; m_stat[7] = 1'b1;
      if (cb_old[7]) m_irx = 1;
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (off || !rd || wr) return 8'h00;
    case (addr)
      3'd0: return m_stat;
      3'd1: return m_cb;
      3'd2: return m_cc;
      3'd4: return m_blo;
      3'd5: return m_bhi;
      3'd6: return (m_cb[4] && m_val) ? (m_dat & m_mask) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit etx;
    etx = !off && rst_n && wr && addr == 3'd6 && m_cb[3];
    chk("rdata", int'(rdata), int'(exp_rdata()));
    chk("rx_ready", int'(rx_ready), int'(rst_n && !off && m_cb[4] && !m_val));
    chk("tx_valid", int'(tx_valid), int'(etx));
    if (etx) chk("tx_data", int'(tx_data), int'(wd));
    chk("baud", int'(baud), int'({m_bhi[3:0], m_blo}));
    chk("irq_rx", int'(irq_rx), int'(m_irx));
    chk("irq_tx", int'(irq_tx), int'(m_itx));
    chk("irq_empty", int'(irq_emp), int'(m_iem));
  endtask

  task automatic step(bit r, bit w, logic [2:0] a, logic [7:0] d, bit v, logic [7:0] b);
    @(negedge clk);
    rd = r; wr = w; addr = a; wd = d; rxv = v; rxd = b;
    #1;
    compare();
    @(posedge clk);
    #1;
    m_tick();
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d); step(0, 1, a, d, 0, 8'h00); endtask
  task automatic rreg(logic [2:0] a); step(1, 0, a, 8'h00, 0, 8'h00); endtask
  task automatic idle(); step(0, 0, 3'd0, 8'h00, 0, 8'h00); endtask
  task automatic push(logic [7:0] b); step(0, 0, 3'd0, 8'h00, 1, b); endtask
  task automatic rd_all(); for (int i = 0; i < 8; i++) rreg(3'(i)); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    req = "R1";
    idle(); idle();
    @(negedge clk); rst_n = 1'b1;
    rd_all();

    req = "R10";
    rreg(3'd3); rreg(3'd7);
    wreg(3'd3, 8'hFF); wreg(3'd7, 8'hFF);
    rd_all();

    req = "R3";
    wreg(3'd1, 8'hFF); rreg(3'd1);
    wreg(3'd2, 8'hA5); rreg(3'd2);
    wreg(3'd4, 8'h5A); wreg(3'd5, 8'hFF); rreg(3'd4); rreg(3'd5);
    wreg(3'd2, 8'h06); wreg(3'd1, 8'h00); idle();

    req = "R2";
    wreg(3'd0, 8'hFF); rreg(3'd0);
    wreg(3'd0, 8'h00); rreg(3'd0);

    req = "R7";
    wreg(3'd6, 8'h33); rreg(3'd0);
    wreg(3'd1, 8'h08); wreg(3'd6, 8'h41); idle(); rreg(3'd0);
    wreg(3'd1, 8'h68); wreg(3'd6, 8'h42); idle(); rreg(3'd0);

    req = "R11";
    wreg(3'd6, 8'h55); idle(); idle();
    wreg(3'd6, 8'h56); wreg(3'd6, 8'h57); idle();

    req = "R8";
    wreg(3'd1, 8'h08); wreg(3'd6, 8'h10); wreg(3'd1, 8'h48); idle();
    req = "R2";
    wreg(3'd0, 8'h40); rreg(3'd0); idle();
    req = "R8";
    wreg(3'd1, 8'h28); idle(); wreg(3'd1, 8'h08); idle();

    req = "R5";
    wreg(3'd1, 8'h90); push(8'hC3);
    push(8'h3C); push(8'h3C); push(8'h3C); rreg(3'd0);

    req = "R6";
    rreg(3'd6); rreg(3'd6); rreg(3'd0);

    req = "R4";
    wreg(3'd2, 8'h00); push(8'hFF); rreg(3'd6);
    wreg(3'd2, 8'h02); push(8'hFF); rreg(3'd6);
    wreg(3'd2, 8'h04); push(8'hFF); rreg(3'd6);
    wreg(3'd2, 8'h06); wreg(3'd1, 8'h94); push(8'hFF); rreg(3'd6);
    wreg(3'd2, 8'h00); push(8'hFF); rreg(3'd6);
    wreg(3'd1, 8'h90); wreg(3'd2, 8'h00); push(8'hFF); rreg(3'd6);
    wreg(3'd1, 8'h94); push(8'hFF); rreg(3'd6);

    req = "R6";
    wreg(3'd1, 8'h90); wreg(3'd2, 8'h06); push(8'hA5);
    wreg(3'd1, 8'h00); rreg(3'd6); rreg(3'd0);
    wreg(3'd1, 8'h10); rreg(3'd6); rreg(3'd0);

    req = "R5";
    wreg(3'd1, 8'h00); push(8'h11); wreg(3'd1, 8'h10); rreg(3'd6);
    push(8'h22); rreg(3'd6);

    req = "R9";
    wreg(3'd1, 8'hFC); wreg(3'd4, 8'h77); push(8'h5E);
    off = 1'b1;
    rreg(3'd1); wreg(3'd1, 8'hFF); push(8'h12); rreg(3'd0); wreg(3'd6, 8'h99);
    off = 1'b0;
    rd_all();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule